// File: doc/BRIEF.md
# Dual-Slot Frame Playback Sequencer

This block steps through frame sequences held in an external frame store. Two playback slots each hold a base address, a number of frames and a number of repeats. A programmable period sets the length of a frame in clock cycles. On each new frame the block issues a one-cycle strobe along with the memory address of that frame. Frames advance by a programmable stride, and the address returns to the slot base at the start of every repeat. The blocks that read memory, decompress and drive the display follow these outputs.

A control word starts and stops playback. It also chooses which slot plays first, whether playback moves on to the other slot when the current one is used up, whether the whole arrangement wraps around without end, and whether the block halts by itself after the last slot. On a self-halt the light enable drops and a one-cycle done pulse is raised. Busy stays high from the start of playback until the block halts. All settings arrive on a simple write-only register port. The mode bits are captured at the moment playback starts.

Top module: `vidseq_top`

## Requirements
- R1: After reset busy, light_en, frame_strobe and done are low and frame_addr is 0.
- R2: Registers are written by wr_en/wr_addr/wr_data. The offsets are: 0 frame period, 1 frame stride, 2 slot-0 base, 3 slot-0 setup, 4 slot-1 base, 5 slot-1 setup, 6 control. A setup word carries frames in bits [11:0] and repeats in bits [19:12]. The control bits are: bit0 start, bit1 halt, bit2 alternate, bit3 wrap-all, bit4 first-slot select, bit5 self-halt. A control write with start=1 and halt=0 raises busy, light_en and frame_strobe on that same clock edge. It presents the base of the selected slot (select 0 means slot 0) and sets cur_slot to that slot.
- R3: Strobes inside a run are spaced exactly by the period value in cycles, and a period of 0 behaves as 1.
- R4: Within a repeat each strobe's address is the previous address plus the stride. Every repeat restarts at the slot base. A slot plays its frames times its repeats strobes.
- R5: With alternate set, once the first slot has used all its repeats, the next strobe comes from the other slot at that slot's base.
- R6: With self-halt set and wrap-all clear, one period after the last strobe of the final slot, busy and light_en fall and done is high for exactly one cycle.
- R7: With wrap-all set, after the final slot the sequence restarts at the first slot without end, and self-halt has no effect (done never rises).
- R8: A control write with halt=1 ends playback at the next frame boundary. No further strobe occurs, busy and light_en fall within one period, and done stays low. Halt beats start: writing both while idle leaves busy low.
- R9: A repeat count of 0 means endless repeats of that slot when alternate is clear. With alternate set it counts as one pass.
- R10: A slot with a frame count of 0 yields no strobes and counts as finished at once. Playback then goes on with the next slot.
- R11: With alternate giving a final slot, and with wrap-all and self-halt both clear, the block holds after the last frame. busy and light_en stay high, no further strobes occur, and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | RA_W (3) | Register offset |
| wr_data | input | DATA_W (24) | Register write data |
| frame_addr | output | ADDR_W (24) | Memory address of the current frame |
| frame_strobe | output | 1 | One-cycle pulse at the start of each frame |
| light_en | output | 1 | Light source enable |
| busy | output | 1 | Playback active (including hold) |
| done | output | 1 | One-cycle pulse on a self-halt |
| cur_slot | output | 1 | Slot currently playing |

## Verification
The risky overlap is a halt request that arrives on the same edge as a frame boundary. On that edge the sequencer may emit a strobe, move to the other slot or finish on its own. A start and a halt may also arrive in the same write. The bench issues halt writes at many offsets within a frame, after random runs with random periods, and one start+halt write while idle. It judges the result at the ports: a strobe on the write edge itself is allowed, but none may follow it. Busy must fall within one period and done must stay low.

// File: rtl/vidseq_pkg.sv
package vidseq_pkg;

    // register offsets on the write port
    localparam int REG_PERIOD  = 0;
    localparam int REG_STRIDE  = 1;
    localparam int REG_S0_BASE = 2;
    localparam int REG_S0_CFG  = 3;
    localparam int REG_CTRL    = 6;
    localparam int SLOT_STEP   = 2;
    localparam int NUM_SLOTS   = 2;

    // control word bit positions
    localparam int CB_START    = 0;
    localparam int CB_HALT     = 1;
    localparam int CB_ALT      = 2;
    localparam int CB_WRAP     = 3;
    localparam int CB_FIRST    = 4;
    localparam int CB_SELFHALT = 5;

    typedef struct packed {
        logic alternate;
        logic wrap_all;
        logic first;
        logic self_halt;
    } mode_t;

endpackage

// File: rtl/vidseq_regs.sv
module vidseq_regs
    import vidseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PER_W  = 16,
    parameter int FCNT_W = 12,
    parameter int LCNT_W = 8,
    parameter int DATA_W = 24,
    parameter int RA_W   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [RA_W-1:0]                  wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [PER_W-1:0]                 period,
    output logic [ADDR_W-1:0]                stride,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] base,
    output logic [NUM_SLOTS-1:0][FCNT_W-1:0] frames,
    output logic [NUM_SLOTS-1:0][LCNT_W-1:0] loops,
    output logic                             ctl_wr,
    output logic                             ctl_start,
    output logic                             ctl_halt,
    output mode_t                            ctl_mode
);

    localparam int LOOP_LSB = FCNT_W;

    typedef struct packed {
        logic [PER_W-1:0]                 period;
        logic [ADDR_W-1:0]                stride;
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] base;
        logic [NUM_SLOTS-1:0][FCNT_W-1:0] frames;
        logic [NUM_SLOTS-1:0][LCNT_W-1:0] loops;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == RA_W'(REG_PERIOD)) r_d.period = wr_data[PER_W-1:0];
            if (wr_addr == RA_W'(REG_STRIDE)) r_d.stride = wr_data[ADDR_W-1:0];
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_addr == RA_W'(REG_S0_BASE + SLOT_STEP*s))
                    r_d.base[s] = wr_data[ADDR_W-1:0];
                if (wr_addr == RA_W'(REG_S0_CFG + SLOT_STEP*s)) begin
                    r_d.frames[s] = wr_data[FCNT_W-1:0];
                    r_d.loops[s]  = wr_data[LOOP_LSB +: LCNT_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign period = r_q.period;
    assign stride = r_q.stride;
    assign base   = r_q.base;
    assign frames = r_q.frames;
    assign loops  = r_q.loops;

    // the control word acts on the edge it is written; mode is captured by the sequencer
    assign ctl_wr             = wr_en && (wr_addr == RA_W'(REG_CTRL));
    assign ctl_start          = wr_data[CB_START];
    assign ctl_halt           = wr_data[CB_HALT];
    assign ctl_mode.alternate = wr_data[CB_ALT];
    assign ctl_mode.wrap_all  = wr_data[CB_WRAP];
    assign ctl_mode.first     = wr_data[CB_FIRST];
    assign ctl_mode.self_halt = wr_data[CB_SELFHALT];

endmodule

// File: rtl/vidseq_timer.sv
module vidseq_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    logic [PER_W-1:0] cnt_d, cnt_q;

    // last cycle of a frame: count+1 reaches period (period 0 acts as 1)
    assign tick = run && (({1'b0, cnt_q} + 1'b1) >= {1'b0, period});

    always_comb begin
        if (!run || restart) cnt_d = '0;
        else if (tick)       cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/vidseq_core.sv
module vidseq_core
    import vidseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int FCNT_W = 12,
    parameter int LCNT_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                stride,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] base,
    input  logic [NUM_SLOTS-1:0][FCNT_W-1:0] frames,
    input  logic [NUM_SLOTS-1:0][LCNT_W-1:0] loops,
    input  logic                             ctl_wr,
    input  logic                             ctl_start,
    input  logic                             ctl_halt,
    input  mode_t                            ctl_mode,
    input  logic                             tick,
    output logic                             strobe_next,
    output logic                             running,
    output logic [ADDR_W-1:0]                frame_addr,
    output logic                             frame_strobe,
    output logic                             light_en,
    output logic                             done,
    output logic                             cur_slot
);

    typedef struct packed {
        logic              run;
        logic              light;
        logic              hold;
        logic              skip;
        logic              halt_pend;
        logic              slot;
        logic [FCNT_W-1:0] fidx;
        logic [LCNT_W-1:0] lidx;
        logic [ADDR_W-1:0] addr;
        logic              strobe;
        logic              done;
        mode_t             mode;
    } seq_t;

    seq_t s_d, s_q;

    logic              advance;
    logic              slot_finished;
    logic              is_last;
    logic              do_enter;
    logic              enter_slot;
    logic [FCNT_W:0]   fnext;
    logic [LCNT_W:0]   lnext;
    logic              loop_forever;

    assign advance      = s_q.run && (s_q.skip || tick);
    assign fnext        = {1'b0, s_q.fidx} + 1'b1;
    assign lnext        = {1'b0, s_q.lidx} + 1'b1;
    assign loop_forever = (loops[s_q.slot] == '0) && !s_q.mode.alternate;
    assign is_last      = s_q.mode.alternate ? (s_q.slot != s_q.mode.first) : 1'b1;

    always_comb begin
        s_d           = s_q;
        s_d.strobe    = 1'b0;
        s_d.done      = 1'b0;
        slot_finished = 1'b0;
        do_enter      = 1'b0;
        enter_slot    = s_q.slot;

        // frame boundary: pending halt first, then next frame, next repeat or slot end
        if (advance) begin
            if (s_q.halt_pend) begin
                s_d.run       = 1'b0;
                s_d.light     = 1'b0;
                s_d.hold      = 1'b0;
                s_d.skip      = 1'b0;
                s_d.halt_pend = 1'b0;
            end else if (s_q.hold) begin
                s_d.hold = 1'b1;
            end else if (s_q.skip) begin
                slot_finished = 1'b1;
            end else if (fnext < {1'b0, frames[s_q.slot]}) begin
                s_d.fidx   = fnext[FCNT_W-1:0];
                s_d.addr   = s_q.addr + stride;
                s_d.strobe = 1'b1;
            end else if (loop_forever || (lnext < {1'b0, loops[s_q.slot]})) begin
                s_d.lidx   = lnext[LCNT_W-1:0];
                s_d.fidx   = '0;
                s_d.addr   = base[s_q.slot];
                s_d.strobe = 1'b1;
            end else begin
                slot_finished = 1'b1;
            end
        end

        // slot used up: move on, wrap, halt by itself or hold
        if (slot_finished) begin
            if (!is_last) begin
                do_enter   = 1'b1;
                enter_slot = ~s_q.slot;
            end else if (s_q.mode.wrap_all) begin
                do_enter   = 1'b1;
                enter_slot = s_q.mode.first;
            end else if (s_q.mode.self_halt) begin
                s_d.run   = 1'b0;
                s_d.light = 1'b0;
                s_d.skip  = 1'b0;
                s_d.done  = 1'b1;
            end else begin
                s_d.hold = 1'b1;
                s_d.skip = 1'b0;
            end
        end

        // control write: halt has priority over start
        if (ctl_wr && ctl_halt) begin
            if (s_d.run) s_d.halt_pend = 1'b1;
        end else if (ctl_wr && ctl_start) begin
            s_d.mode      = ctl_mode;
            s_d.run       = 1'b1;
            s_d.light     = 1'b1;
            s_d.hold      = 1'b0;
            s_d.halt_pend = 1'b0;
            s_d.done      = 1'b0;
            do_enter      = 1'b1;
            enter_slot    = ctl_mode.first;
        end

        // entering a slot: an empty slot is skipped on the following cycle
        if (do_enter) begin
            s_d.slot = enter_slot;
            s_d.fidx = '0;
            s_d.lidx = '0;
            if (frames[enter_slot] == '0) begin
                s_d.skip   = 1'b1;
                s_d.strobe = 1'b0;
            end else begin
                s_d.skip   = 1'b0;
                s_d.addr   = base[enter_slot];
                s_d.strobe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strobe_next  = s_d.strobe;
    assign running      = s_q.run;
    assign frame_addr   = s_q.addr;
    assign frame_strobe = s_q.strobe;
    assign light_en     = s_q.light;
    assign done         = s_q.done;
    assign cur_slot     = s_q.slot;

endmodule

// File: rtl/vidseq_top.sv
module vidseq_top
    import vidseq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int PER_W  = 16,
    parameter int FCNT_W = 12,
    parameter int LCNT_W = 8,
    parameter int DATA_W = 24,
    parameter int RA_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] frame_addr,
    output logic              frame_strobe,
    output logic              light_en,
    output logic              busy,
    output logic              done,
    output logic              cur_slot
);

    logic [PER_W-1:0]                 period;
    logic [ADDR_W-1:0]                stride;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] base;
    logic [NUM_SLOTS-1:0][FCNT_W-1:0] frames;
    logic [NUM_SLOTS-1:0][LCNT_W-1:0] loops;
    logic                             ctl_wr;
    logic                             ctl_start;
    logic                             ctl_halt;
    mode_t                            ctl_mode;
    logic                             tick;
    logic                             strobe_next;
    logic                             running;

    vidseq_regs #(
        .ADDR_W(ADDR_W), .PER_W(PER_W), .FCNT_W(FCNT_W),
        .LCNT_W(LCNT_W), .DATA_W(DATA_W), .RA_W(RA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .period(period), .stride(stride), .base(base), .frames(frames), .loops(loops),
        .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_halt(ctl_halt), .ctl_mode(ctl_mode)
    );

    vidseq_timer #(.PER_W(PER_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running), .restart(strobe_next),
        .period(period), .tick(tick)
    );

    vidseq_core #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .LCNT_W(LCNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .stride(stride), .base(base), .frames(frames),
        .loops(loops), .ctl_wr(ctl_wr), .ctl_start(ctl_start), .ctl_halt(ctl_halt),
        .ctl_mode(ctl_mode), .tick(tick), .strobe_next(strobe_next), .running(running),
        .frame_addr(frame_addr), .frame_strobe(frame_strobe), .light_en(light_en),
        .done(done), .cur_slot(cur_slot)
    );

    assign busy = running;

endmodule

// File: rtl/vidseq_chk.sv
module vidseq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] frame_addr,
    input logic              frame_strobe,
    input logic              light_en,
    input logic              busy,
    input logic              done
);

    // R2
    strobe_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> (busy && light_en));

    // R4
    addr_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> $stable(frame_addr));

    // R6
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_blanks_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !light_en));

    // R6
    done_ends_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R8
    light_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !light_en);

endmodule

bind vidseq_top vidseq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_addr(frame_addr), .frame_strobe(frame_strobe),
    .light_en(light_en), .busy(busy), .done(done)
);

// File: tb/vidseq_top_tb.sv
module vidseq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [23:0]   wr_data = '0;
    logic [AW-1:0] frame_addr;
    logic          frame_strobe, light_en, busy, done, cur_slot;

    vidseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_addr(frame_addr), .frame_strobe(frame_strobe), .light_en(light_en),
        .busy(busy), .done(done), .cur_slot(cur_slot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // captured strobes and done pulses
    int            sc_cyc[$];
    logic [AW-1:0] sc_addr[$];
    bit            sc_slot[$];
    int            done_cnt = 0;
    int            done_cyc = 0;

    always @(negedge clk) begin
        if (frame_strobe) begin
            sc_cyc.push_back(cyc);
            sc_addr.push_back(frame_addr);
            sc_slot.push_back(cur_slot);
        end
        if (done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    int checks = 0;
    int errs   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bench configuration
    logic [AW-1:0] b_base[2];
    int            b_fr[2];
    int            b_lp[2];
    int            b_per;
    logic [AW-1:0] b_stride;
    bit            b_alt, b_first, b_wrap, b_self;

    logic [AW-1:0] exp_addr[$];
    bit            exp_slot[$];

    function automatic int peff();
        return (b_per == 0) ? 1 : b_per;
    endfunction

    // expected strobe list: nested slot / repeat / frame loops
    task automatic build_exp(input int cap);
        exp_addr.delete();
        exp_slot.delete();
        for (int rep = 0; rep < (b_wrap ? 1000 : 1) && exp_addr.size() < cap; rep++) begin
            for (int k = 0; k < (b_alt ? 2 : 1); k++) begin
                bit s;
                int nl;
                s = (k == 0) ? b_first : !b_first;
                if (b_fr[s] == 0) continue;
                nl = (b_lp[s] == 0) ? (b_alt ? 1 : 1000000) : b_lp[s];
                for (int l = 0; l < nl && exp_addr.size() < cap; l++) begin
                    for (int f = 0; f < b_fr[s] && exp_addr.size() < cap; f++) begin
                        exp_addr.push_back(AW'(b_base[s] + AW'(f) * b_stride));
                        exp_slot.push_back(s);
                    end
                end
            end
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = 24'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic int ctrl_word(input bit start, input bit halt);
        return int'(start) | (int'(halt) << 1) | (int'(b_alt) << 2) | (int'(b_wrap) << 3)
             | (int'(b_first) << 4) | (int'(b_self) << 5);
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_halt(input string req);
        int w, d0, late;
        d0 = done_cnt;
        wr(6, 2);
        w = cyc;
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
        chk(!busy && (cyc - w) <= peff(), req, "halt latency", cyc - w, peff());
        chk(!light_en, req, "light after halt", light_en, 0);
        late = 0;
        foreach (sc_cyc[i]) if (sc_cyc[i] > w) late++;
        chk(late == 0, req, "strobes after halt", late, 0);
        chk(done_cnt == d0, req, "done on halt", done_cnt - d0, 0);
    endtask

    task automatic run_case(input string tag);
        bit inf, zero;
        int cap, w, n, m, bad_a, bad_s, bad_t;
        inf  = b_wrap || (!b_alt && b_lp[b_first] == 0 && b_fr[b_first] != 0);
        zero = (b_fr[0] == 0) || (b_fr[1] == 0);
        cap  = inf ? 20 : 100000;
        build_exp(cap);
        wr(0, b_per);
        wr(1, int'(b_stride));
        wr(2, int'(b_base[0]));
        wr(3, (b_lp[0] << 12) | b_fr[0]);
        wr(4, int'(b_base[1]));
        wr(5, (b_lp[1] << 12) | b_fr[1]);
        sc_cyc.delete(); sc_addr.delete(); sc_slot.delete();
        done_cnt = 0;
        wr(6, ctrl_word(1'b1, 1'b0));
        w = cyc;
        n = 0;
        if (inf)
            while (sc_cyc.size() < exp_addr.size() && n < 5000) begin @(negedge clk); n++; end
        else if (b_self)
            while (done_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
        else
            wait_cycles(exp_addr.size() * peff() + 4 * peff() + 4);

        if (inf) chk(sc_cyc.size() >= exp_addr.size(), tag, "strobe count", sc_cyc.size(), exp_addr.size());
        else     chk(sc_cyc.size() == exp_addr.size(), tag, "strobe count", sc_cyc.size(), exp_addr.size());

        m = (sc_cyc.size() < exp_addr.size()) ? sc_cyc.size() : exp_addr.size();
        bad_a = 0; bad_s = 0; bad_t = 0;
        for (int i = 0; i < m; i++) begin
            if (sc_addr[i] != exp_addr[i]) begin
                if (bad_a == 0) chk(1'b0, tag, $sformatf("R4 address of strobe %0d", i), sc_addr[i], exp_addr[i]);
                bad_a++;
            end
            if (sc_slot[i] != exp_slot[i]) begin
                if (bad_s == 0) chk(1'b0, tag, $sformatf("R5 slot of strobe %0d", i), sc_slot[i], exp_slot[i]);
                bad_s++;
            end
            if (!zero && i > 0 && (sc_cyc[i] - sc_cyc[i-1]) != peff()) begin
                if (bad_t == 0) chk(1'b0, "R3", $sformatf("spacing before strobe %0d", i), sc_cyc[i] - sc_cyc[i-1], peff());
                bad_t++;
            end
        end
        if (bad_a == 0) chk(1'b1, tag, "R4 addresses", 0, 0);
        if (bad_s == 0) chk(1'b1, tag, "R5 slots", 0, 0);
        if (bad_t == 0) chk(1'b1, "R3", "spacing", 0, 0);

        if (m > 0)
            chk(sc_cyc[0] == w + ((b_fr[b_first] == 0) ? 1 : 0), "R2", "first strobe cycle",
                sc_cyc[0] - w, (b_fr[b_first] == 0) ? 1 : 0);

        if (!inf && b_self) begin
            chk(done_cnt == 1, "R6", "done pulse", done_cnt, 1);
            if (sc_cyc.size() > 0)
                chk(done_cyc == sc_cyc[sc_cyc.size()-1] + peff(), "R6", "done timing",
                    done_cyc - sc_cyc[sc_cyc.size()-1], peff());
            wait_cycles(2);
            chk(!busy && !light_en, "R6", "busy/light after done", {busy, light_en}, 0);
            chk(done_cnt == 1, "R6", "done width", done_cnt, 1);
        end else begin
            if (b_wrap && b_self) chk(done_cnt == 0, "R7", "done in wrap mode", done_cnt, 0);
            if (!inf && !b_self) begin
                chk(busy && light_en, "R11", "hold keeps busy/light", {busy, light_en}, 3);
                chk(done_cnt == 0, "R11", "done in hold", done_cnt, 0);
            end
            wait_cycles(int'($urandom_range(0, 7)));
            do_halt("R8");
        end
        wait_cycles(3);
    endtask

    task automatic set_slots(input int a0, input int f0, input int l0,
                             input int a1, input int f1, input int l1);
        b_base[0] = AW'(a0); b_fr[0] = f0; b_lp[0] = l0;
        b_base[1] = AW'(a1); b_fr[1] = f1; b_lp[1] = l1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        wait_cycles(5);
        // R1 reset state
        chk(!busy && !light_en && !frame_strobe && !done && frame_addr == '0, "R1",
            "reset outputs", {busy, light_en, frame_strobe, done}, 0);
        rst_n = 1'b1;
        wait_cycles(2);
        chk(!busy && !light_en && !frame_strobe && !done, "R1", "idle after reset",
            {busy, light_en, frame_strobe, done}, 0);

        // alternate then self-halt (R5, R6)
        b_per = 4; b_stride = 24'h10;
        b_alt = 1; b_first = 0; b_wrap = 0; b_self = 1;
        set_slots(24'h100, 3, 2, 24'h800, 2, 1);
        run_case("R4");

        // starting from slot 1 (R2, R5)
        b_first = 1; b_per = 0;
        run_case("R5");

        // wrap-all ignores self-halt (R7)
        b_first = 0; b_wrap = 1; b_per = 3;
        run_case("R7");

        // zero repeats: endless without alternate, one pass with it (R9)
        b_wrap = 0; b_alt = 0; b_self = 1;
        set_slots(24'h200, 2, 0, 24'h900, 1, 1);
        run_case("R9");
        b_alt = 1;
        run_case("R9");

        // empty slot skipped (R10)
        set_slots(24'h300, 0, 2, 24'hA00, 3, 1);
        b_first = 0; b_per = 2;
        run_case("R10");

        // hold after final slot (R11)
        b_self = 0; b_alt = 1;
        set_slots(24'h400, 1, 1, 24'hB00, 2, 2);
        run_case("R11");

        // halt and start in one write while idle (R8)
        sc_cyc.delete(); sc_addr.delete(); sc_slot.delete();
        wr(6, 3);
        wait_cycles(4);
        chk(!busy && !light_en, "R8", "halt beats start", {busy, light_en}, 0);
        chk(sc_cyc.size() == 0, "R8", "no strobe on halt+start", sc_cyc.size(), 0);

        // random cases
        for (int t = 0; t < 14; t++) begin
            b_per    = int'($urandom_range(1, 6));
            b_stride = AW'($urandom_range(1, 255));
            b_alt    = 1'($urandom_range(0, 1));
            b_first  = 1'($urandom_range(0, 1));
            b_wrap   = 1'($urandom_range(0, 1));
            b_self   = 1'($urandom_range(0, 1));
            set_slots(int'($urandom_range(0, 24'hFFFFFF)), int'($urandom_range(1, 4)),
                      int'($urandom_range(0, 3)),
                      int'($urandom_range(0, 24'hFFFFFF)), int'($urandom_range(1, 4)),
                      int'($urandom_range(0, 3)));
            run_case("R4");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule